// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns segment:offset pairs into flat physical addresses. It holds four segment base registers and an instruction pointer. The physical address is the selected segment value moved up by a fixed number of bit positions, plus the offset. The sum is cut to the physical address width, so any carry past the top bit is dropped and the address wraps.

Each request carries an access kind. The kind picks the default segment:

- A code fetch uses the code segment. Its offset is the internal instruction pointer, not the offset input.
- The other kinds use the offset input.
- An override input can redirect plain data and stack accesses to any segment. It has no effect on code fetches or string destinations.

Software can write the segment registers directly. The instruction pointer moves only by a jump load or by stepping after each fetch. Results come out registered, one cycle after the request, with a valid strobe.

A reset filter protects the state. The registers return to their architected values only after the reset input has been sampled low on several consecutive clocks. Shorter glitches are ignored.

Top module: `seg_addr_gen`

## Requirements
- R1: `addr_out` equals `(segment << 4) + offset`, truncated to 20 bits, so a carry out of bit 19 is discarded. Example: segment A4FB with offset 4872 gives A9822.
- R2: Segment ids are 0 code, 1 data, 2 stack and 3 extra. Access kinds map to a default segment and offset as follows:
  - 0 (fetch) uses the code segment with the instruction pointer.
  - 1 (data) uses the data segment with `req_offset`.
  - 2 (stack) uses the stack segment with `req_offset`.
  - 3 (string destination) uses the extra segment with `req_offset`.
- R3: When `ovr_en` is high, `ovr_seg` replaces the segment for kinds 1 and 2 only. It has no effect on kinds 0 and 3.
- R4: After `rst_n` has been sampled low on 4 consecutive rising edges, the state is reset:
  - the code segment is FFFF and the other segments are 0000;
  - the instruction pointer is 0000;
  - `addr_valid` is low.
  The first fetch after reset therefore gives FFFF0.
- R5: A low pulse on `rst_n` that spans fewer than 4 rising edges changes no segment, instruction pointer or address state.
- R6: A write through `seg_we`/`seg_sel`/`seg_wdata` is visible to requests from the next cycle on. A request in the same cycle uses the old value.
- R7: Each fetch advances the instruction pointer by 1 when `fetch_wide` is 0, and by 2 when it is 1. The pointer wraps within 16 bits.
- R8: `ip_load` sets the instruction pointer to `ip_target` and takes precedence over a fetch step. A fetch in the same cycle uses the pointer value from before the load.
- R9: `addr_valid` is high in the cycle after a request and only then. `addr_out` holds the address of that request.
- R10: Requests of kinds 1, 2 and 3 leave the instruction pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. It takes effect after 4 consecutive low samples. |
| seg_we | input | 1 | Segment register write enable |
| seg_sel | input | 2 | Segment id to write |
| seg_wdata | input | 16 | New segment value |
| ip_load | input | 1 | Load the instruction pointer (jump) |
| ip_target | input | 16 | Jump target for the instruction pointer |
| req_valid | input | 1 | Address request strobe |
| req_kind | input | 2 | Access kind (see R2) |
| req_offset | input | 16 | Offset for access kinds other than fetch |
| ovr_en | input | 1 | Segment override enable |
| ovr_seg | input | 2 | Override segment id |
| fetch_wide | input | 1 | Fetch step size: 0 steps by one, 1 steps by two |
| addr_valid | output | 1 | Registered result strobe |
| addr_out | output | 20 | Registered physical address |

## Verification
The bench builds the block with its default parameters:

- 16-bit segments and offsets, a 4-bit shift and a 20-bit result;
- a reset hold of 4 clocks;
- a code segment reset value of FFFF.

With these values, a three-clock reset pulse and a four-clock reset pulse fall either side of the filter threshold, so both outcomes can be checked. The reset code segment already sits at the top of the space, so a pointer of 0010 is enough to show the 20-bit wrap. Loading pointer FFFF and fetching wide shows the 16-bit pointer wrap without a long run of fetches.

// File: rtl/seg_addr_pkg.sv
// Package: shared encodings for the segmented address generator.
// Assumes the segment ids and the access kinds both fit in two bits.
package seg_addr_pkg;

    // Segment register identifiers
    typedef enum logic [1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_id_e;

    // Access kinds carried with a request
    typedef enum logic [1:0] {
        ACC_FETCH  = 2'd0,
        ACC_DATA   = 2'd1,
        ACC_STACK  = 2'd2,
        ACC_STRDST = 2'd3
    } acc_kind_e;

    localparam int NUM_SEG = 4;

endpackage

// File: rtl/seg_rst_filter.sv
// seg_rst_filter: qualifies the raw active-low reset.
// What it does: asserts rst_apply only on the edge at which rst_n has been
// sampled low for HOLD consecutive clocks (the current sample included).
// Assumes: HOLD >= 2; rst_n is synchronous to clk.
module seg_rst_filter #(
    parameter int HOLD = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic rst_apply
);
    localparam int HW = HOLD - 1;

    logic [HW-1:0] hist_q;

    generate
        if (HW == 1) begin : g_one
            // Keep the previous reset sample
            always_ff @(posedge clk) hist_q <= rst_n;
        end else begin : g_many
            // Shift in the latest reset samples
            always_ff @(posedge clk) hist_q <= {hist_q[HW-2:0], rst_n};
        end
    endgenerate

    // Reset is applied when the current and all held samples are low
    always_comb rst_apply = !rst_n && (hist_q == '0);

endmodule

// File: rtl/seg_reg_file.sv
// seg_reg_file: segment base registers and instruction pointer.
// What it does: holds NUM_SEG segment values (code segment resets to
// CS_RESET, the rest to zero) and the instruction pointer (resets to
// IP_RESET). The pointer is loaded on a jump or stepped by one or two.
// Assumes: rst_apply comes from the reset filter; loads beat steps.
module seg_reg_file
    import seg_addr_pkg::*;
#(
    parameter int          SEG_W    = 16,
    parameter int          OFF_W    = 16,
    parameter logic [15:0] CS_RESET = 16'hFFFF,
    parameter logic [15:0] IP_RESET = 16'h0000
) (
    input  logic                            clk,
    input  logic                            rst_apply,
    input  logic                            seg_we,
    input  logic [1:0]                      seg_sel,
    input  logic [SEG_W-1:0]                seg_wdata,
    input  logic                            ip_load,
    input  logic [OFF_W-1:0]                ip_target,
    input  logic                            ip_step,
    input  logic                            step_wide,
    output logic [NUM_SEG-1:0][SEG_W-1:0]   seg_vals,
    output logic [OFF_W-1:0]                ip_val
);
    logic [OFF_W-1:0] ip_q;
    logic [OFF_W-1:0] ip_inc;

    generate
        for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
            localparam logic [SEG_W-1:0] RST_V =
                (i == int'(SEG_CODE)) ? SEG_W'(CS_RESET) : '0;
            logic [SEG_W-1:0] seg_q;
            // Hold one segment base, written when selected
            always_ff @(posedge clk) begin
                if (rst_apply)
                    seg_q <= RST_V;
                else if (seg_we && (seg_sel == 2'(i)))
                    seg_q <= seg_wdata;
            end
            assign seg_vals[i] = seg_q;
        end
    endgenerate

    // Step amount for the instruction pointer, wrapping in OFF_W bits
    always_comb ip_inc = ip_q + (step_wide ? OFF_W'(2) : OFF_W'(1));

    // Instruction pointer: reset, jump load, or fetch step
    always_ff @(posedge clk) begin
        if (rst_apply)
            ip_q <= OFF_W'(IP_RESET);
        else if (ip_load)
            ip_q <= ip_target;
        else if (ip_step)
            ip_q <= ip_inc;
    end

    assign ip_val = ip_q;

    // R4
    reset_values_chk: assert property (@(posedge clk) disable iff (rst_apply)
        $past(rst_apply) |-> (ip_q == OFF_W'(IP_RESET)) &&
                             (seg_vals[int'(SEG_CODE)] == SEG_W'(CS_RESET)));
    // R6
    seg_write_lands_chk: assert property (@(posedge clk) disable iff (rst_apply)
        seg_we |=> seg_vals[$past(seg_sel)] == $past(seg_wdata));
    // R8
    ip_load_chk: assert property (@(posedge clk) disable iff (rst_apply)
        ip_load |=> ip_q == $past(ip_target));
    // R7
    ip_step_chk: assert property (@(posedge clk) disable iff (rst_apply)
        (ip_step && !ip_load) |=>
            ip_q == $past(ip_q) + ($past(step_wide) ? OFF_W'(2) : OFF_W'(1)));
    // R10
    ip_hold_chk: assert property (@(posedge clk) disable iff (rst_apply)
        (!ip_step && !ip_load) |=> $stable(ip_q));

endmodule

// File: rtl/seg_select.sv
// seg_select: picks segment and offset for a request.
// What it does: maps the access kind to its default segment, applies an
// override for data and stack kinds only, and chooses the instruction
// pointer as offset for fetches.
// Assumes: purely combinational; the caller registers the result.
module seg_select
    import seg_addr_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16
) (
    input  logic [1:0]                    req_kind,
    input  logic                          ovr_en,
    input  logic [1:0]                    ovr_seg,
    input  logic [OFF_W-1:0]              req_offset,
    input  logic [OFF_W-1:0]              ip_val,
    input  logic [NUM_SEG-1:0][SEG_W-1:0] seg_vals,
    output logic [1:0]                    sel_id,
    output logic [SEG_W-1:0]              sel_seg,
    output logic [OFF_W-1:0]              sel_off
);
    acc_kind_e kind;

    // Decode the access kind and apply the override rules
    always_comb begin
        kind = acc_kind_e'(req_kind);
        unique case (kind)
            ACC_FETCH:  sel_id = 2'(SEG_CODE);
            ACC_STRDST: sel_id = 2'(SEG_EXTRA);
            ACC_DATA:   sel_id = ovr_en ? ovr_seg : 2'(SEG_DATA);
            ACC_STACK:  sel_id = ovr_en ? ovr_seg : 2'(SEG_STACK);
            default:    sel_id = 2'(SEG_DATA);
        endcase
    end

    // Route the chosen segment and offset
    always_comb begin
        sel_seg = seg_vals[sel_id];
        sel_off = (kind == ACC_FETCH) ? ip_val : req_offset;
    end

endmodule

// File: rtl/seg_adder.sv
// seg_adder: shift-and-add physical address former.
// What it does: returns (seg << SHIFT) + off truncated to PA_W bits.
// Assumes: OFF_W <= PA_W; the carry out of the top bit is dropped.
module seg_adder #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    parameter int PA_W  = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    output logic [PA_W-1:0]  phys
);
    logic [PA_W-1:0] base;
    logic [PA_W-1:0] ext_off;

    // Align the base and add the offset, wrapping at PA_W bits
    always_comb begin
        base    = PA_W'(seg) << SHIFT;
        ext_off = PA_W'(off);
        phys    = base + ext_off;
    end

endmodule

// File: rtl/seg_addr_gen.sv
// seg_addr_gen: segmented physical address generator (top).
// What it does: filters reset, keeps segment and pointer state, selects
// the segment and offset per request, forms the address and registers it
// with a valid strobe one cycle after the request.
// Assumes: all inputs are synchronous to clk; one request per cycle.
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int          SEG_W    = 16,
    parameter int          OFF_W    = 16,
    parameter int          SHIFT    = 4,
    parameter int          RST_HOLD = 4,
    parameter logic [15:0] CS_RESET = 16'hFFFF,
    parameter logic [15:0] IP_RESET = 16'h0000,
    localparam int         PA_W     = SEG_W + SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seg_we,
    input  logic [1:0]       seg_sel,
    input  logic [SEG_W-1:0] seg_wdata,
    input  logic             ip_load,
    input  logic [OFF_W-1:0] ip_target,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic [OFF_W-1:0] req_offset,
    input  logic             ovr_en,
    input  logic [1:0]       ovr_seg,
    input  logic             fetch_wide,
    output logic             addr_valid,
    output logic [PA_W-1:0]  addr_out
);
    logic                           rst_apply;
    logic                           is_fetch;
    logic [NUM_SEG-1:0][SEG_W-1:0]  seg_vals;
    logic [OFF_W-1:0]               ip_val;
    logic [1:0]                     sel_id;
    logic [SEG_W-1:0]               sel_seg;
    logic [OFF_W-1:0]               sel_off;
    logic [PA_W-1:0]                phys;
    logic                           valid_q;
    logic [PA_W-1:0]                addr_q;

    // A fetch steps the instruction pointer
    always_comb is_fetch = req_valid && (req_kind == 2'(ACC_FETCH));

    seg_rst_filter #(.HOLD(RST_HOLD)) u_rst (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_apply (rst_apply)
    );

    seg_reg_file #(
        .SEG_W(SEG_W), .OFF_W(OFF_W),
        .CS_RESET(CS_RESET), .IP_RESET(IP_RESET)
    ) u_regs (
        .clk       (clk),
        .rst_apply (rst_apply),
        .seg_we    (seg_we),
        .seg_sel   (seg_sel),
        .seg_wdata (seg_wdata),
        .ip_load   (ip_load),
        .ip_target (ip_target),
        .ip_step   (is_fetch),
        .step_wide (fetch_wide),
        .seg_vals  (seg_vals),
        .ip_val    (ip_val)
    );

    seg_select #(.SEG_W(SEG_W), .OFF_W(OFF_W)) u_sel (
        .req_kind   (req_kind),
        .ovr_en     (ovr_en),
        .ovr_seg    (ovr_seg),
        .req_offset (req_offset),
        .ip_val     (ip_val),
        .seg_vals   (seg_vals),
        .sel_id     (sel_id),
        .sel_seg    (sel_seg),
        .sel_off    (sel_off)
    );

    seg_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .PA_W(PA_W)) u_add (
        .seg  (sel_seg),
        .off  (sel_off),
        .phys (phys)
    );

    // Output register: strobe follows the request, address held otherwise
    always_ff @(posedge clk) begin
        if (rst_apply) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
        end else begin
            valid_q <= req_valid;
            if (req_valid)
                addr_q <= phys;
        end
    end

    assign addr_valid = valid_q;
    assign addr_out   = addr_q;

    // R9
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst_apply)
        req_valid |=> addr_valid);
    // R9
    valid_quiet_chk: assert property (@(posedge clk) disable iff (rst_apply)
        !req_valid |=> !addr_valid);
    // R2
    fetch_code_chk: assert property (@(posedge clk) disable iff (rst_apply)
        (req_kind == 2'(ACC_FETCH)) |-> (sel_id == 2'(SEG_CODE)) && (sel_off == ip_val));
    // R3
    strdst_fixed_chk: assert property (@(posedge clk) disable iff (rst_apply)
        (req_kind == 2'(ACC_STRDST)) |-> (sel_id == 2'(SEG_EXTRA)) && (sel_off == req_offset));
    // R4
    reset_quiet_chk: assert property (@(posedge clk)
        rst_apply |=> !addr_valid);

endmodule

// File: tb/seg_addr_gen_test.sv
// Scoreboard bench: driver tasks push expected addresses, a monitor pops.
module seg_addr_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_we = 1'b0;
    logic [1:0]  seg_sel = '0;
    logic [15:0] seg_wdata = '0;
    logic        ip_load = 1'b0;
    logic [15:0] ip_target = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [15:0] req_offset = '0;
    logic        ovr_en = 1'b0;
    logic [1:0]  ovr_seg = '0;
    logic        fetch_wide = 1'b0;
    logic        addr_valid;
    logic [19:0] addr_out;

    int tests = 0;
    int fails = 0;

    // Model state
    logic [15:0] m_seg [4];
    logic [15:0] m_ip;

    // Scoreboard
    logic [19:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    seg_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .seg_we(seg_we), .seg_sel(seg_sel),
        .seg_wdata(seg_wdata), .ip_load(ip_load), .ip_target(ip_target),
        .req_valid(req_valid), .req_kind(req_kind), .req_offset(req_offset),
        .ovr_en(ovr_en), .ovr_seg(ovr_seg), .fetch_wide(fetch_wide),
        .addr_valid(addr_valid), .addr_out(addr_out)
    );

    task automatic check(input bit ok, input string req, input logic [19:0] act,
                         input logic [19:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
        end
    endtask

    // Monitor: pop and compare whenever a result is presented
    always @(negedge clk) begin
        if (addr_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected valid", addr_out, 20'h0);
            end else begin
                logic [19:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(addr_out == e, t, addr_out, e);
            end
        end
    end

    // One cycle of stimulus; expectation computed from the model
    task automatic cyc(input bit rv, input logic [1:0] kind, input logic [15:0] off,
                       input bit oe, input logic [1:0] os, input bit wide,
                       input bit swe, input logic [1:0] ssel, input logic [15:0] sdat,
                       input bit ipl, input logic [15:0] ipt, input string tag);
        if (rv) begin
            logic [1:0] s;
            logic [15:0] o;
            case (kind)
                2'd0: s = 2'd0;
                2'd3: s = 2'd3;
                default: s = oe ? os : kind;
            endcase
            o = (kind == 2'd0) ? m_ip : off;
            exp_q.push_back(({4'h0, m_seg[s]} << 4) + {4'h0, o});
            tag_q.push_back(tag);
        end
        req_valid = rv; req_kind = kind; req_offset = off;
        ovr_en = oe; ovr_seg = os; fetch_wide = wide;
        seg_we = swe; seg_sel = ssel; seg_wdata = sdat;
        ip_load = ipl; ip_target = ipt;
        @(posedge clk);
        if (swe) m_seg[ssel] = sdat;
        if (ipl) m_ip = ipt;
        else if (rv && kind == 2'd0) m_ip = m_ip + (wide ? 16'd2 : 16'd1);
        @(negedge clk);
        req_valid = 0; seg_we = 0; ip_load = 0; ovr_en = 0;
    endtask

    task automatic req(input logic [1:0] kind, input logic [15:0] off, input bit oe,
                       input logic [1:0] os, input bit wide, input string tag);
        cyc(1, kind, off, oe, os, wide, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic wseg(input logic [1:0] s, input logic [15:0] v);
        cyc(0, 0, 0, 0, 0, 0, 1, s, v, 0, 0, "");
    endtask

    task automatic pulse_reset(input int n);
        rst_n = 0;
        repeat (n) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        if (n >= 4) begin
            m_seg[0] = 16'hFFFF; m_seg[1] = 0; m_seg[2] = 0; m_seg[3] = 0;
            m_ip = 16'h0000;
        end
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog expired actual=%05h expected=%05h", 20'h0, 20'h0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        m_seg[0] = 16'hFFFF; m_seg[1] = 0; m_seg[2] = 0; m_seg[3] = 0; m_ip = 0;
        repeat (6) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(addr_valid == 1'b0, "R4 valid low after reset", {19'h0, addr_valid}, 20'h0);
        // R4 first fetch FFFF0, R7 narrow then wide steps
        req(0, 0, 0, 0, 0, "R4 first fetch");
        req(0, 0, 0, 0, 1, "R7 narrow step");
        req(0, 0, 0, 0, 0, "R7 wide step");
        // R9 idle cycle shows no strobe
        @(negedge clk);
        check(addr_valid == 1'b0, "R9 idle no valid", {19'h0, addr_valid}, 20'h0);
        // R1 worked example
        wseg(1, 16'hA4FB);
        req(1, 16'h4872, 0, 0, 0, "R1 data A9822");
        check(addr_out == 20'hA9822, "R1 literal", addr_out, 20'hA9822);
        // R1 wrap at 20 bits via code FFFF, ip 0010
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 16'h0010, "");
        req(0, 0, 0, 0, 0, "R1 wrap 20 bits");
        // R2 stack and string destination defaults
        wseg(2, 16'h1234);
        wseg(3, 16'h2000);
        req(2, 16'hFFFF, 0, 0, 0, "R2 stack default");
        req(3, 16'h0010, 0, 0, 0, "R2 extra default");
        // R3 override on string destination and fetch ignored, honoured on data and stack
        req(3, 16'h0010, 1, 1, 0, "R3 strdst ignores override");
        req(0, 0, 1, 2, 0, "R3 fetch ignores override");
        req(1, 16'h0004, 1, 2, 0, "R3 data overridden to stack");
        req(2, 16'h0008, 1, 3, 0, "R3 stack overridden to extra");
        // R10 non-fetch accesses keep pointer: fetch now reflects unchanged ip
        req(0, 0, 0, 0, 0, "R10 ip unchanged by data access");
        // R6 same-cycle write uses old value, next cycle new
        cyc(1, 1, 16'h0001, 0, 0, 0, 1, 1, 16'h0300, 0, 0, "R6 old segment value");
        req(1, 16'h0001, 0, 0, 0, "R6 new segment value");
        // R8 load with fetch uses old ip, then jump target
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 16'h0100, "R8 fetch uses old ip");
        req(0, 0, 0, 0, 0, "R8 fetch at target");
        // R7 16-bit wrap: ip FFFF wide -> 0001
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 16'hFFFF, "");
        req(0, 0, 0, 0, 1, "R7 fetch at FFFF");
        req(0, 0, 0, 0, 0, "R7 ip wrapped");
        // R5 short pulse keeps state
        pulse_reset(3);
        req(0, 0, 0, 0, 0, "R5 ip kept after short pulse");
        req(1, 16'h0002, 0, 0, 0, "R5 data segment kept");
        // R4 full reset restores values
        pulse_reset(4);
        @(negedge clk);
        check(addr_valid == 1'b0, "R4 valid low", {19'h0, addr_valid}, 20'h0);
        req(0, 0, 0, 0, 0, "R4 fetch FFFF0 again");
        req(1, 16'h0005, 0, 0, 0, "R4 data segment zero");
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R9 all results seen", 20'(exp_q.size()), 20'h0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule